// File: doc/BRIEF.md
# Transmit Character Input Register with Idle Fill

This block is the parallel input stage of a character-oriented serial transmitter. On each rising edge of the word clock it decides whether a new character is taken from the parallel inputs. A character is an 8-bit byte, a flag that marks the byte as a control code rather than a data symbol, and a flag that requests a deliberate code violation. The registered result goes to the line encoder, which is outside this block.

There are two active-low load strobes. The immediate strobe loads the inputs that are present on the same edge. The deferred strobe marks the following edge as a load edge, and the inputs present on that edge are taken. This lets the block sit behind either a FIFO that presents data combinationally or one whose output is registered one word-clock cycle later, with no glue logic. On any edge where neither strobe calls for a load, the register holds the K28.5 comma instead, so the link always carries idle fill. A valid flag tells the encoder whether the character came from the inputs or from fill.

Top module: `txin_reg`

## Requirements
- R1: On a load edge the register takes `tx_byte`, `tx_ctrl` and `tx_viol` and presents them unchanged on `ch_byte`, `ch_ctrl` and `ch_viol` after that edge. `ch_ctrl` high marks a control code and low marks a data symbol.
- R2: When `load_now_n` is low at a rising edge, the inputs sampled at that edge are presented after it with `ch_valid` high.
- R3: When `load_next_n` is low at a rising edge, the inputs sampled at the next rising edge are presented after that next edge with `ch_valid` high, whatever `load_now_n` is on that next edge.
- R4: On an edge that is not a load edge, the output becomes the fill character: `ch_byte` = 0xBC, `ch_ctrl` = 1, `ch_viol` = 0. The inputs on that edge have no effect.
- R5: `ch_valid` is 1 for a character taken from the inputs and 0 for fill. A byte of 0xBC loaded from the inputs with `tx_ctrl` = 1 still shows `ch_valid` = 1.
- R6: If both strobes are low at the same edge, that edge loads, and the following edge loads as well.
- R7: A rising edge with `rst` high forces fill with `ch_valid` = 0 and cancels any load that `load_next_n` had scheduled. The first edge after reset loads only if `load_now_n` is low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit word clock |
| rst | input | 1 | Synchronous reset, active high |
| load_now_n | input | 1 | Immediate load strobe, active low |
| load_next_n | input | 1 | Deferred load strobe, active low; loads on the following edge |
| tx_byte | input | 8 | Character byte |
| tx_ctrl | input | 1 | 1 = control code, 0 = data symbol |
| tx_viol | input | 1 | Request for a deliberate code violation |
| ch_byte | output | 8 | Registered character byte to the encoder |
| ch_ctrl | output | 1 | Registered control/data flag |
| ch_viol | output | 1 | Registered violation request |
| ch_valid | output | 1 | 1 = character came from the inputs, 0 = idle fill |

## Verification
An immediate load shows up one edge after its strobe. A deferred load shows up two edges after its strobe, because the inputs sampled on the middle edge are the ones taken. Fill and reset also take effect one edge later. The bench drives each vector on a falling edge and compares the outputs on the next falling edge, which is one register stage after the edge that used the vector. A deferred strobe is therefore checked on the row after the one that carries it. The reset tests follow the same timing and check the edge during reset and the first edge after it.

// File: rtl/txin_pkg.sv
package txin_pkg;
  localparam int CHAR_W = 8;
  localparam logic [CHAR_W-1:0] COMMA_BYTE = 8'hBC;

  typedef struct packed {
    logic [CHAR_W-1:0] byte_v;
    logic              ctrl;
    logic              viol;
    logic              valid;
  } txchar_t;

  function automatic txchar_t fill_char();
    txchar_t c;
    c.byte_v = COMMA_BYTE;
    c.ctrl   = 1'b1;
    c.viol   = 1'b0;
    c.valid  = 1'b0;
    return c;
  endfunction
endpackage

// File: rtl/txin_sched.sv
module txin_sched (
  input  logic clk,
  input  logic rst,
  input  logic load_now_n,
  input  logic load_next_n,
  output logic take
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= ~load_next_n;
  end

  assign take = ~load_now_n | armed_q;

  AST_NEXT_ARMS: assert property (@(posedge clk) disable iff (rst)
    !load_next_n |=> take); // R3
endmodule

// File: rtl/txin_select.sv
module txin_select
  import txin_pkg::*;
(
  input  logic              take,
  input  logic [CHAR_W-1:0] in_byte,
  input  logic              in_ctrl,
  input  logic              in_viol,
  output txchar_t           next_char
);
  always_comb begin
    if (take) begin
      next_char.byte_v = in_byte;
      next_char.ctrl   = in_ctrl;
      next_char.viol   = in_viol;
      next_char.valid  = 1'b1;
    end else begin
      next_char = fill_char();
    end
  end
endmodule

// File: rtl/txin_reg.sv
module txin_reg
  import txin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_now_n,
  input  logic              load_next_n,
  input  logic [CHAR_W-1:0] tx_byte,
  input  logic              tx_ctrl,
  input  logic              tx_viol,
  output logic [CHAR_W-1:0] ch_byte,
  output logic              ch_ctrl,
  output logic              ch_viol,
  output logic              ch_valid
);
  logic    take;
  txchar_t next_char;
  txchar_t char_q;

  txin_sched u_sched (
    .clk         (clk),
    .rst         (rst),
    .load_now_n  (load_now_n),
    .load_next_n (load_next_n),
    .take        (take)
  );

  txin_select u_select (
    .take      (take),
    .in_byte   (tx_byte),
    .in_ctrl   (tx_ctrl),
    .in_viol   (tx_viol),
    .next_char (next_char)
  );

  always_ff @(posedge clk) begin
    if (rst) char_q <= fill_char();
    else     char_q <= next_char;
  end

  assign ch_byte  = char_q.byte_v;
  assign ch_ctrl  = char_q.ctrl;
  assign ch_viol  = char_q.viol;
  assign ch_valid = char_q.valid;

  AST_NOW_LOADS: assert property (@(posedge clk) disable iff (rst)
    !load_now_n |=> ch_valid && ch_byte == $past(tx_byte)
      && ch_ctrl == $past(tx_ctrl) && ch_viol == $past(tx_viol)); // R2
  AST_NEXT_LOADS: assert property (@(posedge clk) disable iff (rst)
    !load_next_n |-> ##2 ch_valid); // R3
  AST_FILL_FORM: assert property (@(posedge clk) disable iff (rst)
    !ch_valid |-> ch_byte == COMMA_BYTE && ch_ctrl && !ch_viol); // R4
  AST_IDLE_FILLS: assert property (@(posedge clk) disable iff (rst)
    !take |=> !ch_valid); // R5
  AST_RESET_FILL: assert property (@(posedge clk)
    rst |=> !ch_valid && ch_byte == COMMA_BYTE); // R7
endmodule

// File: tb/txin_reg_tb_top.sv
module txin_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_now_n = 1'b1;
  logic       load_next_n = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_ctrl = 1'b0;
  logic       tx_viol = 1'b0;
  logic [7:0] ch_byte;
  logic       ch_ctrl, ch_viol, ch_valid;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  txin_reg dut_i (
    .clk(clk), .rst(rst), .load_now_n(load_now_n), .load_next_n(load_next_n),
    .tx_byte(tx_byte), .tx_ctrl(tx_ctrl), .tx_viol(tx_viol),
    .ch_byte(ch_byte), .ch_ctrl(ch_ctrl), .ch_viol(ch_viol), .ch_valid(ch_valid)
  );

  // now_n, next_n, byte, ctrl, viol, expected valid
  localparam int N = 14;
  localparam logic [12:0] VEC [N] = '{
    {1'b1, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},  // R4 idle
    {1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b1},  // R2 immediate, control code
    {1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0},  // R3 deferred strobe: fill now
    {1'b1, 1'b1, 8'h22, 1'b0, 1'b1, 1'b1},  // R3 deferred load
    {1'b1, 1'b1, 8'h33, 1'b0, 1'b0, 1'b0},  // R4
    {1'b0, 1'b0, 8'h44, 1'b0, 1'b0, 1'b1},  // R6 both strobes
    {1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 1'b1},  // R6 following edge
    {1'b1, 1'b0, 8'h66, 1'b0, 1'b0, 1'b0},  // R3
    {1'b1, 1'b0, 8'h77, 1'b0, 1'b0, 1'b1},  // R3 back to back
    {1'b1, 1'b1, 8'h88, 1'b0, 1'b0, 1'b1},  // R3
    {1'b1, 1'b1, 8'h99, 1'b1, 1'b1, 1'b0},  // R4 inputs ignored
    {1'b0, 1'b1, 8'hBC, 1'b1, 1'b0, 1'b1},  // R5 loaded comma is valid
    {1'b0, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1},  // R1 all flags
    {1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1}   // R6 trailing load
  };

  task automatic drive(input logic nw, input logic nx, input logic [7:0] b,
                       input logic c, input logic v);
    load_now_n = nw; load_next_n = nx; tx_byte = b; tx_ctrl = c; tx_viol = v;
  endtask

  task automatic expect_out(input string req, input logic ev, input logic [7:0] eb,
                            input logic ec, input logic evi);
    total++;
    if (ch_valid !== ev || ch_byte !== eb || ch_ctrl !== ec || ch_viol !== evi) begin
      bad++;
      $display("FAIL %s: got v=%b b=%h c=%b x=%b, exp v=%b b=%h c=%b x=%b",
               req, ch_valid, ch_byte, ch_ctrl, ch_viol, ev, eb, ec, evi);
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: got hang, exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    expect_out("R7 reset state", 1'b0, 8'hBC, 1'b1, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      drive(VEC[i][12], VEC[i][11], VEC[i][10:3], VEC[i][2], VEC[i][1]);
      @(negedge clk);
      if (VEC[i][0]) expect_out("R1/R2/R3/R5/R6 load", 1'b1, VEC[i][10:3], VEC[i][2], VEC[i][1]);
      else           expect_out("R4/R5 fill", 1'b0, 8'hBC, 1'b1, 1'b0);
    end
    // R7: a deferred load scheduled before reset is cancelled
    drive(1'b1, 1'b0, 8'h5A, 1'b0, 1'b1);
    @(negedge clk);
    expect_out("R3 strobe edge fill", 1'b0, 8'hBC, 1'b1, 1'b0);
    rst = 1'b1;
    drive(1'b0, 1'b1, 8'h6B, 1'b0, 1'b0);
    @(negedge clk);
    expect_out("R7 reset overrides load", 1'b0, 8'hBC, 1'b1, 1'b0);
    rst = 1'b0;
    drive(1'b1, 1'b1, 8'h7C, 1'b0, 1'b1);
    @(negedge clk);
    expect_out("R7 pending cleared", 1'b0, 8'hBC, 1'b1, 1'b0);
    // R7: deferred strobe held through reset does not load after it
    drive(1'b1, 1'b0, 8'h12, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 1'b1, 8'h34, 1'b1, 1'b1);
    @(negedge clk);
    expect_out("R7 no load after reset", 1'b0, 8'hBC, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 8'h56, 1'b0, 1'b1);
    @(negedge clk);
    expect_out("R2 first load after reset", 1'b1, 8'h56, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule